// File: doc/BRIEF.md
# Hysteresis Threshold Sample Discriminator

This block sits in front of a capture store and decides, lane by lane, which incoming samples are kept. Each lane has a high and a low threshold. A lane that is idle wakes when a sample goes above its high threshold. It then keeps passing samples until one drops below its low threshold. Kept samples leave on a per-lane output stream, one cycle after they arrive.

Each time a lane wakes, the block also emits one timetag for that lane. The timetag joins two values: a free-running cycle counter, and the lane's stored-sample index. The stored-sample index is the position that the waking sample will take in downstream storage. A single clear pulse, normally raised when a new capture starts, resets the stored-sample indices of every lane together.

The thresholds for all lanes are loaded together from one wide configuration word, accepted on a valid strobe.

Top module: `hyst_discriminator`

## Requirements
- R1: While reset is high, and afterwards, `out_valid` and `ts_valid` are low until a sample qualifies. Reset sets every threshold to all ones. As a result, no sample is forwarded until a configuration is loaded, not even 16'hFFFF.
- R2: `in_ready` and `cfg_ready` are held at 1 at all times.
- R3: Configuration layout and timing:
  - Lane c takes bits `[32c+31 : 32c]` of `cfg_data`, with the high threshold in the upper 16 bits and the low threshold in the lower 16 bits.
  - The word is captured only in a cycle with `cfg_valid` high. Changes to `cfg_data` while `cfg_valid` is low have no effect.
  - New thresholds apply to every lane at once, starting with the sample accepted in the next cycle.
- R4: An idle lane becomes active on an accepted sample that is strictly greater (unsigned) than its high threshold. That sample is forwarded.
- R5: An active lane forwards every accepted sample that is greater than or equal to its low threshold. A sample strictly below the low threshold makes the lane idle and is not forwarded.
- R6: When a lane's high and low thresholds are equal and every sample is at or below them, nothing is forwarded on that lane.
- R7: A forwarded sample appears on `out_data[16c+15:16c]` with `out_valid[c]` high for exactly one cycle. This happens in the cycle after the sample was accepted. A cycle with `in_valid[c]` low produces no output and does not change the lane's state.
- R8: In the cycle a lane's forwarded sample appears because the lane just became active, `ts_valid[c]` is also high. `ts_data` for lane c is `{zero padding, cycle count [IDX_W+CLK_W-1:IDX_W], stored-sample index [IDX_W-1:0]}`.
  - The cycle count is the counter value at the accepting clock edge.
  - The stored-sample index is the count of samples forwarded on that lane since the last clear, not counting this sample.
  - IDX_W is clog2(BUF_DEPTH*N_CH).
  - The timetag width is 16 times ceil((IDX_W+CLK_W)/16).
- R9: A lane's stored-sample index rises by one for each sample forwarded on it. A one-cycle `idx_clear` pulse zeroes the index of every lane. A sample forwarded in the clear cycle takes index 0.
- R10: The cycle counter is 0 during reset. It rises by one on every clock edge after reset, wraps at CLK_W bits, and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_CH | Per-lane sample valid |
| in_data | input | N_CH*SW | Per-lane samples, lane c at bits [SW*c +: SW] |
| in_ready | output | 1 | Always 1 |
| cfg_valid | input | 1 | Load strobe for the threshold word |
| cfg_data | input | 2*N_CH*SW | Per-lane {high, low} threshold pairs |
| cfg_ready | output | 1 | Always 1 |
| idx_clear | input | 1 | Clears all stored-sample indices |
| out_valid | output | N_CH | Per-lane forwarded-sample valid |
| out_data | output | N_CH*SW | Per-lane forwarded samples |
| ts_valid | output | N_CH | Per-lane timetag valid |
| ts_data | output | N_CH*TS_W | Per-lane timetags |

## Verification
The two lanes are driven with different threshold pairs.
- One lane has a wide hysteresis band. Samples exactly at the high threshold, one count above it, exactly at the low threshold and one count below it separate strict from non-strict comparisons in both directions.
- The other lane has equal thresholds. It shows that samples at or below a single level never pass, while one count above wakes the lane.

Gaps in `in_valid` on one lane while the other keeps streaming show that state is held across idle cycles. A reload of the configuration that wakes one lane and drops the other in the same cycle shows that both lanes switch thresholds together. Timetags taken around a clear pulse and across the counter wrap tell index bookkeeping apart from counter bookkeeping.

// File: rtl/hd_pkg.sv
package hd_pkg;
  function automatic int ts_width(input int idx_w, input int clk_w, input int sw);
    return sw * ((idx_w + clk_w + sw - 1) / sw);
  endfunction
endpackage

// File: rtl/hd_timebase.sv
module hd_timebase #(
  parameter int CLK_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CLK_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hd_thresholds.sv
module hd_thresholds #(
  parameter int N_CH = 2,
  parameter int SW   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_valid,
  input  logic [2*N_CH*SW-1:0]     cfg_data,
  output logic [N_CH-1:0][SW-1:0]  hi,
  output logic [N_CH-1:0][SW-1:0]  lo
);
  localparam int PAIR_W = 2 * SW;

  for (genvar c = 0; c < N_CH; c++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst) begin
        hi[c] <= '1;
        lo[c] <= '1;
      end else if (cfg_valid) begin
        hi[c] <= cfg_data[PAIR_W*c + SW +: SW];
        lo[c] <= cfg_data[PAIR_W*c      +: SW];
      end
    end
  end
endmodule

// File: rtl/hd_lane.sv
module hd_lane #(
  parameter int SW    = 16,
  parameter int IDX_W = 11,
  parameter int CLK_W = 48,
  parameter int TS_W  = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vin,
  input  logic [SW-1:0]    smp,
  input  logic [SW-1:0]    hi,
  input  logic [SW-1:0]    lo,
  input  logic             clr,
  input  logic [CLK_W-1:0] cnt,
  output logic             ov,
  output logic [SW-1:0]    od,
  output logic             tv,
  output logic [TS_W-1:0]  td
);
  logic             act_q, act_d;
  logic             keep, rise;
  logic [IDX_W-1:0] idx_q, idx_base;
  logic [TS_W-1:0]  tag;

  always_comb begin
    act_d = act_q;
    if (!act_q && (smp > hi))     act_d = 1'b1;
    else if (act_q && (smp < lo)) act_d = 1'b0;
    keep     = vin && act_d;
    rise     = vin && !act_q && act_d;
    idx_base = clr ? '0 : idx_q;
    tag      = '0;
    tag[IDX_W-1:0]      = idx_base;
    tag[IDX_W +: CLK_W] = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      idx_q <= '0;
      ov    <= 1'b0;
      tv    <= 1'b0;
      od    <= '0;
      td    <= '0;
    end else begin
      ov    <= keep;
      tv    <= rise;
      idx_q <= idx_base + IDX_W'(keep);
      if (vin)  act_q <= act_d;
      if (keep) od    <= smp;
      if (rise) td    <= tag;
    end
  end
endmodule

// File: rtl/hyst_discriminator.sv
module hyst_discriminator #(
  parameter int N_CH      = 2,
  parameter int SW        = 16,
  parameter int BUF_DEPTH = 1024,
  parameter int CLK_W     = 48,
  localparam int IDX_W    = $clog2(BUF_DEPTH * N_CH),
  localparam int TS_W     = hd_pkg::ts_width(IDX_W, CLK_W, SW)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_CH-1:0]        in_valid,
  input  logic [N_CH*SW-1:0]     in_data,
  output logic                   in_ready,
  input  logic                   cfg_valid,
  input  logic [2*N_CH*SW-1:0]   cfg_data,
  output logic                   cfg_ready,
  input  logic                   idx_clear,
  output logic [N_CH-1:0]        out_valid,
  output logic [N_CH*SW-1:0]     out_data,
  output logic [N_CH-1:0]        ts_valid,
  output logic [N_CH*TS_W-1:0]   ts_data
);
  logic [CLK_W-1:0]          tick_cnt;
  logic [N_CH-1:0][SW-1:0]   thr_hi, thr_lo;

  assign in_ready  = 1'b1;
  assign cfg_ready = 1'b1;

  hd_timebase #(.CLK_W(CLK_W)) u_time (
    .clk(clk), .rst(rst), .cnt(tick_cnt)
  );

  hd_thresholds #(.N_CH(N_CH), .SW(SW)) u_thr (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
    .hi(thr_hi), .lo(thr_lo)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_lane
    hd_lane #(.SW(SW), .IDX_W(IDX_W), .CLK_W(CLK_W), .TS_W(TS_W)) u_lane (
      .clk(clk),
      .rst(rst),
      .vin(in_valid[c]),
      .smp(in_data[SW*c +: SW]),
      .hi(thr_hi[c]),
      .lo(thr_lo[c]),
      .clr(idx_clear),
      .cnt(tick_cnt),
      .ov(out_valid[c]),
      .od(out_data[SW*c +: SW]),
      .tv(ts_valid[c]),
      .td(ts_data[TS_W*c +: TS_W])
    );
  end
endmodule

// File: rtl/hd_checker.sv
module hd_checker #(
  parameter int N_CH  = 2,
  parameter int CLK_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic [N_CH-1:0]  in_valid,
  input logic             in_ready,
  input logic             cfg_ready,
  input logic [N_CH-1:0]  out_valid,
  input logic [N_CH-1:0]  ts_valid,
  input logic [CLK_W-1:0] tick_cnt
);
  // R2
  ready_high_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready && cfg_ready);

  // R7
  out_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((out_valid & ~$past(in_valid)) == '0));

  // R8
  tag_with_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (ts_valid & ~out_valid) == '0);

  // R10
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tick_cnt == CLK_W'($past(tick_cnt) + 1'b1));
endmodule

bind hyst_discriminator hd_checker #(.N_CH(N_CH), .CLK_W(CLK_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .cfg_ready(cfg_ready), .out_valid(out_valid), .ts_valid(ts_valid),
  .tick_cnt(tick_cnt)
);

// File: tb/sim_hyst_discriminator.sv
`timescale 1ns / 1ps
module sim_hyst_discriminator;
  localparam int N_CH  = 2;
  localparam int SW    = 16;
  localparam int DEPTH = 1024;
  localparam int CLK_W = 8;
  localparam int IDX_W = $clog2(DEPTH * N_CH);
  localparam int TS_W  = SW * ((IDX_W + CLK_W + SW - 1) / SW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [N_CH-1:0]      in_valid = '0;
  logic [N_CH*SW-1:0]   in_data = '0;
  logic                 in_ready, cfg_ready;
  logic                 cfg_valid = 1'b0;
  logic [2*N_CH*SW-1:0] cfg_data = '0;
  logic                 idx_clear = 1'b0;
  logic [N_CH-1:0]      out_valid, ts_valid;
  logic [N_CH*SW-1:0]   out_data;
  logic [N_CH*TS_W-1:0] ts_data;

  hyst_discriminator #(.N_CH(N_CH), .SW(SW), .BUF_DEPTH(DEPTH), .CLK_W(CLK_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg_ready(cfg_ready),
    .idx_clear(idx_clear), .out_valid(out_valid), .out_data(out_data),
    .ts_valid(ts_valid), .ts_data(ts_data)
  );

  int checks = 0;
  int fails  = 0;
  logic [CLK_W-1:0] mcnt = '0;
  logic [IDX_W-1:0] midx [N_CH];

  always @(posedge clk) mcnt <= rst ? '0 : mcnt + 1'b1;

  typedef struct packed {
    logic [1:0]  v;
    logic [15:0] s0;
    logic [15:0] s1;
    logic [1:0]  k;
    logic [1:0]  r;
  } row_t;

  // lane 0: high 0x0400 / low 0x01C0 ; lane 1: high = low = 0x0200
  localparam row_t TBL [12] = '{
    '{2'b11, 16'h0300, 16'h0100, 2'b00, 2'b00},
    '{2'b11, 16'h0400, 16'h0200, 2'b00, 2'b00},
    '{2'b11, 16'h0401, 16'h0201, 2'b11, 2'b11},
    '{2'b11, 16'h01c0, 16'h0200, 2'b11, 2'b00},
    '{2'b01, 16'h0300, 16'h0000, 2'b01, 2'b00},
    '{2'b11, 16'h01bf, 16'h01ff, 2'b00, 2'b00},
    '{2'b11, 16'h03ff, 16'h01ff, 2'b00, 2'b00},
    '{2'b10, 16'hffff, 16'h0300, 2'b10, 2'b10},
    '{2'b11, 16'hffff, 16'h0250, 2'b11, 2'b01},
    '{2'b00, 16'h0000, 16'h0000, 2'b00, 2'b00},
    '{2'b11, 16'h0000, 16'h0000, 2'b00, 2'b00},
    '{2'b01, 16'h0500, 16'h0000, 2'b01, 2'b01}
  };

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [15:0] h0, l0, h1, l1);
    cfg_data  = {h1, l1, h0, l0};
    cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  // drive one cycle at a negedge, check the registered result one cycle later
  task automatic step(input logic [1:0] v, input logic [15:0] s0, s1, input logic clr,
                      input logic [1:0] ek, er, input string tag);
    logic [CLK_W-1:0] c = mcnt;
    logic [IDX_W-1:0] base [N_CH];
    logic [TS_W-1:0]  et;
    logic [15:0]      sm [N_CH];
    sm[0] = s0; sm[1] = s1;
    in_valid  = v;
    in_data   = {s1, s0};
    idx_clear = clr;
    for (int k = 0; k < N_CH; k++) base[k] = clr ? '0 : midx[k];
    @(negedge clk);
    in_valid  = '0;
    idx_clear = 1'b0;
    for (int k = 0; k < N_CH; k++) begin
      chk(out_valid[k] == ek[k], {tag, " out_valid"}, 64'(out_valid[k]), 64'(ek[k]));
      if (ek[k])
        chk(out_data[SW*k +: SW] == sm[k], {tag, " out_data"}, 64'(out_data[SW*k +: SW]), 64'(sm[k]));
      chk(ts_valid[k] == er[k], {tag, " ts_valid"}, 64'(ts_valid[k]), 64'(er[k]));
      if (er[k]) begin
        et = '0;
        et[IDX_W-1:0]      = base[k];
        et[IDX_W +: CLK_W] = c;
        chk(ts_data[TS_W*k +: TS_W] == et, {tag, " ts_data"}, 64'(ts_data[TS_W*k +: TS_W]), 64'(et));
      end
      midx[k] = base[k] + IDX_W'(ek[k]);
    end
  endtask

  initial begin
    for (int k = 0; k < N_CH; k++) midx[k] = '0;
    repeat (4) @(negedge clk);
    // R1 / R2: state held in reset
    chk(out_valid == '0 && ts_valid == '0, "R1 reset valids", 64'({out_valid, ts_valid}), 64'd0);
    chk(in_ready && cfg_ready, "R2 ready", 64'({in_ready, cfg_ready}), 64'd3);
    rst = 1'b0;
    @(negedge clk);
    // R1: all-ones thresholds block even the largest sample
    step(2'b11, 16'hffff, 16'hffff, 1'b0, 2'b00, 2'b00, "R1 unconfigured");
    load_cfg(16'h0400, 16'h01c0, 16'h0200, 16'h0200);
    // R4 R5 R6 R7 R8 table walk
    for (int i = 0; i < 12; i++)
      step(TBL[i].v, TBL[i].s0, TBL[i].s1, 1'b0, TBL[i].k, TBL[i].r, $sformatf("R4/R5/R6/R7/R8 row%0d", i));
    // R3: data without strobe ignored (lane0 active, lane1 idle)
    cfg_data = '0;
    @(negedge clk);
    step(2'b11, 16'h01c0, 16'h0100, 1'b0, 2'b01, 2'b00, "R3 no strobe");
    // R3: reload changes both lanes together
    load_cfg(16'h0010, 16'h0008, 16'h0010, 16'h0008);
    step(2'b11, 16'h0005, 16'h0011, 1'b0, 2'b10, 2'b10, "R3 reload");
    step(2'b10, 16'h0000, 16'h0001, 1'b0, 2'b00, 2'b00, "R5 lane1 drop");
    // R9: clear with a waking sample takes index 0, then counts up
    step(2'b01, 16'h0020, 16'h0000, 1'b1, 2'b01, 2'b01, "R9 clear");
    step(2'b01, 16'h0020, 16'h0000, 1'b0, 2'b01, 2'b00, "R9 count");
    step(2'b01, 16'h0001, 16'h0000, 1'b0, 2'b00, 2'b00, "R9 drop");
    step(2'b01, 16'h0030, 16'h0000, 1'b0, 2'b01, 2'b01, "R9 index two");
    step(2'b10, 16'h0000, 16'h0040, 1'b0, 2'b10, 2'b10, "R9 other lane cleared");
    step(2'b11, 16'h0001, 16'h0001, 1'b0, 2'b00, 2'b00, "R10 prep");
    // R10: timetags either side of counter wrap
    while (mcnt != '1) @(negedge clk);
    step(2'b01, 16'h0040, 16'h0000, 1'b0, 2'b01, 2'b01, "R10 count max");
    chk(mcnt == '0, "R10 bench wrap", 64'(mcnt), 64'd0);
    step(2'b10, 16'h0000, 16'h0040, 1'b0, 2'b10, 2'b10, "R10 count zero");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule